// File: doc/BRIEF.md
# Dual-Domain Sticky Interrupt Controller

This block collects 49 interrupt sources into two 32-bit banks and holds each one as a sticky status bit. A per-source routing bit decides whether a source's hardware event is recorded in the user domain or in the system domain. Each domain has its own status, enable, set-by-software and write-one-to-clear registers. The block drives one output per source, which is high while the user status bit and the user enable bit of that source are both set. It also drives a single system output, which is high while any enabled system status bit is set.

Software reaches the registers over a plain 32-bit register bus with a byte address. Only word-aligned addresses are decoded. A write takes effect at the clock edge where `wr_en` is sampled high. The read data is registered and appears in the cycle after `rd_en` is sampled high. Source 35 is reserved. Bank 1 holds only the sources from 32 to 48. Every bit position that has no source behind it stays zero in every register.

Top module: `irq_dual_domain_ctrl`

## Requirements
- R1: After reset, every routing, enable and status register reads as zero, every `user_irq` bit is low and `sys_irq` is low.
- R2: Source n lives in bank n/32 at bit n%32, and the register of bank b sits at the offset below plus 4*b. Routing is at 0x08, system enable at 0x10, system set at 0x18, system clear at 0x20, system status at 0x28, user enable at 0x40, user set at 0x48, user clear at 0x50 and user status at 0x58. Routing and both enable registers read back the value last written, limited to the implemented bits.
- R3: Bit 3 of bank 1 (source 35) and bits 17 to 31 of bank 1 are unimplemented (mask 0xFFFE0008). These bits never become set in any register and always read as zero.
- R4: Writing 1 to a bit of a clear register removes that status bit in the next cycle. Writing 0 leaves the bit unchanged.
- R5: Writing 1 to a bit of a set register makes that status bit 1 in the next cycle.
- R6: A high `src_evt[n]` at a clock edge sets status bit n in the user domain when routing bit n is 1, or in the system domain when it is 0. The bit then stays set after the event goes away.
- R7: When a source event and a clear write for the same status bit fall on the same edge, the bit ends up set.
- R8: `user_irq[n]` is high exactly when user status bit n and user enable bit n are both 1.
- R9: `sys_irq` is high exactly when some system status bit and its system enable bit are both 1.
- R10: Read data is valid in the cycle after `rd_en`. Reading a set register, a clear register, an unmapped offset or a misaligned address returns zero.
- R11: A write to a status register or to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 49 | Per-source hardware event, sampled each edge |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 7 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| user_irq | output | 49 | Per-source user interrupt (status AND enable) |
| sys_irq | output | 1 | Combined system interrupt |

## Verification
The assertions assume that `wr_en` and `rd_en` come with a stable address for one edge, and that a clear write of all ones to the user register of bank 0 is checked only while bank 0 sees no source events. The assertions also assume that each edge carries a single bus write, so a set and a clear never reach the same register together. The stimulus drives every bus access and event on the falling edge, holds it for exactly one rising edge, and issues only one bus command per cycle. The one deliberate overlap is the set-versus-clear collision, which joins an event with a clear write and leaves no set write in the same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 7;

    // register kind, taken from address bits [6:3]
    localparam logic [3:0] RK_ROUTE = 4'h1;
    localparam logic [3:0] RK_SEN   = 4'h2;
    localparam logic [3:0] RK_SSET  = 4'h3;
    localparam logic [3:0] RK_SCLR  = 4'h4;
    localparam logic [3:0] RK_SSTA  = 4'h5;
    localparam logic [3:0] RK_UEN   = 4'h8;
    localparam logic [3:0] RK_USET  = 4'h9;
    localparam logic [3:0] RK_UCLR  = 4'hA;
    localparam logic [3:0] RK_USTA  = 4'hB;

    typedef struct packed {
        logic route;
        logic sen;
        logic sset;
        logic sclr;
        logic uen;
        logic uset;
        logic uclr;
    } bank_wr_t;

    typedef struct packed {
        logic [WORD_W-1:0] route;
        logic [WORD_W-1:0] sen;
        logic [WORD_W-1:0] uen;
        logic [WORD_W-1:0] sstat;
        logic [WORD_W-1:0] ustat;
    } bank_state_t;

    // implemented bits of one bank
    function automatic logic [WORD_W-1:0] bank_valid(input int unsigned bank,
                                                     input int unsigned nsrc,
                                                     input int unsigned rsvd);
        logic [WORD_W-1:0] v;
        for (int unsigned i = 0; i < WORD_W; i++) begin
            v[i] = ((bank * WORD_W + i) < nsrc) && ((bank * WORD_W + i) != rsvd);
        end
        return v;
    endfunction

endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec
    import irqc_pkg::*;
#(
    parameter int unsigned BANKS = 2
) (
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    output bank_wr_t [BANKS-1:0]   wr_sel,
    output logic                   rd_hit,
    output logic [3:0]             rd_kind,
    output logic                   rd_bank
);

    logic       aligned;
    logic       in_range;
    logic [3:0] kind;
    logic       bsel;
    logic       readable;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        kind     = addr[6:3];
        bsel     = addr[2];
        in_range = (int'(bsel) < int'(BANKS));

        unique case (kind)
            RK_ROUTE, RK_SEN, RK_SSTA, RK_UEN, RK_USTA: readable = 1'b1;
            default:                                   readable = 1'b0;
        endcase

        rd_hit  = rd_en && aligned && in_range && readable;
        rd_kind = kind;
        rd_bank = bsel;

        wr_sel = '0;
        if (wr_en && aligned && in_range) begin
            unique case (kind)
                RK_ROUTE: wr_sel[bsel].route = 1'b1;
                RK_SEN:   wr_sel[bsel].sen   = 1'b1;
                RK_SSET:  wr_sel[bsel].sset  = 1'b1;
                RK_SCLR:  wr_sel[bsel].sclr  = 1'b1;
                RK_UEN:   wr_sel[bsel].uen   = 1'b1;
                RK_USET:  wr_sel[bsel].uset  = 1'b1;
                RK_UCLR:  wr_sel[bsel].uclr  = 1'b1;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter logic [WORD_W-1:0] VALID = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] evt,
    input  bank_wr_t          wr,
    input  logic [WORD_W-1:0] wdata,
    output bank_state_t       st
);

    bank_state_t       st_d, st_q;
    logic [WORD_W-1:0] to_user, to_sys;
    logic [WORD_W-1:0] s_set, s_clr, u_set, u_clr;

    always_comb begin
        st_d = st_q;

        // events follow the routing currently held
        to_user = evt & st_q.route;
        to_sys  = evt & ~st_q.route;

        s_set = wr.sset ? wdata : '0;
        s_clr = wr.sclr ? wdata : '0;
        u_set = wr.uset ? wdata : '0;
        u_clr = wr.uclr ? wdata : '0;

        if (wr.route) st_d.route = wdata & VALID;
        if (wr.sen)   st_d.sen   = wdata & VALID;
        if (wr.uen)   st_d.uen   = wdata & VALID;

        // clear first, then any set source wins
        st_d.sstat = ((st_q.sstat & ~s_clr) | s_set | to_sys) & VALID;
        st_d.ustat = ((st_q.ustat & ~u_clr) | u_set | to_user) & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int unsigned BANKS = 2
) (
    input  bank_state_t [BANKS-1:0] st,
    input  logic                    rd_hit,
    input  logic [3:0]              rd_kind,
    input  logic                    rd_bank,
    output logic [WORD_W-1:0]       rd_val
);

    bank_state_t sel;

    always_comb begin
        sel    = st[0];
        rd_val = '0;
        for (int b = 0; b < int'(BANKS); b++) begin
            if (int'(rd_bank) == b) sel = st[b];
        end
        if (rd_hit) begin
            unique case (rd_kind)
                RK_ROUTE: rd_val = sel.route;
                RK_SEN:   rd_val = sel.sen;
                RK_SSTA:  rd_val = sel.sstat;
                RK_UEN:   rd_val = sel.uen;
                RK_USTA:  rd_val = sel.ustat;
                default:  rd_val = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_dual_domain_ctrl.sv
module irq_dual_domain_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 49,
    parameter int unsigned RSVD_SRC = 35
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_evt,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic [NUM_SRC-1:0]  user_irq,
    output logic                sys_irq
);

    // address bit 2 selects the bank, so at most two banks are decoded
    localparam int unsigned BANKS = (NUM_SRC + WORD_W - 1) / WORD_W;
    localparam int unsigned PAD_W = BANKS * WORD_W;
    localparam logic [WORD_W-1:0] BANK1_UNUSED = ~bank_valid(1, NUM_SRC, RSVD_SRC);

    logic [PAD_W-1:0]        evt_pad;
    bank_wr_t [BANKS-1:0]    wr_sel;
    bank_state_t [BANKS-1:0] bank_st;
    logic                    rd_hit;
    logic [3:0]              rd_kind;
    logic                    rd_bank;
    logic [WORD_W-1:0]       rd_val;
    logic [BANKS-1:0]        sys_hit;
    logic [WORD_W-1:0]       rdata_d, rdata_q;

    assign evt_pad = PAD_W'(src_evt);

    irqc_regdec #(.BANKS(BANKS)) regdec_i (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_sel  (wr_sel),
        .rd_hit  (rd_hit),
        .rd_kind (rd_kind),
        .rd_bank (rd_bank)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        irqc_bank #(.VALID(bank_valid(b, NUM_SRC, RSVD_SRC))) bank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_pad[b*WORD_W +: WORD_W]),
            .wr    (wr_sel[b]),
            .wdata (wdata),
            .st    (bank_st[b])
        );
        assign sys_hit[b] = |(bank_st[b].sstat & bank_st[b].sen);
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_uirq
        assign user_irq[n] = bank_st[n / WORD_W].ustat[n % WORD_W]
                           & bank_st[n / WORD_W].uen[n % WORD_W];
    end

    assign sys_irq = |sys_hit;

    irqc_rdmux #(.BANKS(BANKS)) rdmux_i (
        .st      (bank_st),
        .rd_hit  (rd_hit),
        .rd_kind (rd_kind),
        .rd_bank (rd_bank),
        .rd_val  (rd_val)
    );

    always_comb begin
        rdata_d = rd_en ? rd_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int unsigned  NUM_SRC = 49,
    parameter logic [31:0]  UNUSED1 = 32'hFFFE0008
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               rd_en,
    input logic [6:0]         addr,
    input logic [31:0]        wdata,
    input logic [31:0]        evt_lo,
    input logic [31:0]        rdata,
    input logic [NUM_SRC-1:0] user_irq,
    input logic               sys_irq,
    input logic [31:0]        ustat0,
    input logic [31:0]        sen0,
    input logic [31:0]        sen1,
    input logic [31:0]        sstat1,
    input logic [31:0]        ustat1
);

    // R1: outputs are quiet in the first cycle after reset release
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (user_irq == '0 && !sys_irq && rdata == '0));

    // R3: unimplemented bank-1 positions never hold status
    a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((sstat1 & UNUSED1) == '0) && ((ustat1 & UNUSED1) == '0));

    // R4: an all-ones user clear with no events empties bank 0
    a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 7'h50 && wdata == 32'hFFFF_FFFF && evt_lo == '0)
        |=> (ustat0 == '0));

    // R6: without a user clear of bank 0 no status bit is lost
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 7'h50)
        |=> ((ustat0 & $past(ustat0)) == $past(ustat0)));

    // R9: with every system enable clear the system output stays low
    a_r9_sys_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sen0 == '0 && sen1 == '0) |-> !sys_irq);

    // R10: reads of set and clear registers return zero
    a_r10_wo_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 7'h18 || addr == 7'h20 || addr == 7'h48 || addr == 7'h50))
        |=> (rdata == '0));

    logic unused_ok;
    assign unused_ok = ^{sstat1[0], wdata[0]} | 1'b1;

endmodule

bind irq_dual_domain_ctrl irqc_chk #(
    .NUM_SRC (NUM_SRC),
    .UNUSED1 (BANK1_UNUSED)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .evt_lo   (src_evt[31:0]),
    .rdata    (rdata),
    .user_irq (user_irq),
    .sys_irq  (sys_irq),
    .ustat0   (bank_st[0].ustat),
    .sen0     (bank_st[0].sen),
    .sen1     (bank_st[1].sen),
    .sstat1   (bank_st[1].sstat),
    .ustat1   (bank_st[1].ustat)
);

// File: tb/irq_dual_domain_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_dual_domain_ctrl_tb_top;

    localparam int NSRC  = 49;
    localparam int NVEC  = 29;
    localparam logic [31:0] B1_OK = 32'h0001_FFF7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_evt = '0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [6:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NSRC-1:0] user_irq;
    logic            sys_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_dual_domain_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  (src_evt),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .user_irq (user_irq),
        .sys_irq  (sys_irq)
    );

    // {write, addr, data or expected read, requirement}
    localparam logic [47:0] VEC [0:NVEC-1] = '{
        {1'b1, 7'h08, 32'hFFFF_FFFF, 8'd2},   // R2 routing bank 0
        {1'b0, 7'h08, 32'hFFFF_FFFF, 8'd2},
        {1'b1, 7'h0C, 32'hFFFF_FFFF, 8'd3},   // R3 routing bank 1
        {1'b0, 7'h0C, B1_OK,         8'd3},
        {1'b1, 7'h10, 32'hA5A5_A5A5, 8'd2},   // R2 system enable
        {1'b0, 7'h10, 32'hA5A5_A5A5, 8'd2},
        {1'b1, 7'h44, 32'hFFFF_FFFF, 8'd2},   // R2 user enable bank 1
        {1'b0, 7'h44, B1_OK,         8'd3},
        {1'b1, 7'h18, 32'h0000_00F0, 8'd5},   // R5 system set
        {1'b0, 7'h28, 32'h0000_00F0, 8'd5},
        {1'b1, 7'h20, 32'h0000_0030, 8'd4},   // R4 system clear
        {1'b0, 7'h28, 32'h0000_00C0, 8'd4},
        {1'b1, 7'h20, 32'h0000_0000, 8'd4},   // R4 zero clear
        {1'b0, 7'h28, 32'h0000_00C0, 8'd4},
        {1'b0, 7'h18, 32'h0000_0000, 8'd10},  // R10 set reg reads zero
        {1'b0, 7'h50, 32'h0000_0000, 8'd10},  // R10 clear reg reads zero
        {1'b1, 7'h4C, 32'hFFFF_FFFF, 8'd5},   // R5 user set bank 1
        {1'b0, 7'h5C, B1_OK,         8'd3},
        {1'b1, 7'h5C, 32'h0000_0000, 8'd11},  // R11 write to status
        {1'b0, 7'h5C, B1_OK,         8'd11},
        {1'b1, 7'h54, 32'hFFFF_FFFF, 8'd4},   // R4 user clear bank 1
        {1'b0, 7'h5C, 32'h0000_0000, 8'd4},
        {1'b1, 7'h30, 32'h1234_5678, 8'd11},  // R11 unmapped write
        {1'b0, 7'h30, 32'h0000_0000, 8'd11},
        {1'b0, 7'h00, 32'h0000_0000, 8'd10},  // R10 unmapped read
        {1'b1, 7'h10, 32'h0000_0000, 8'd2},
        {1'b1, 7'h44, 32'h0000_0000, 8'd2},
        {1'b1, 7'h20, 32'hFFFF_FFFF, 8'd4},
        {1'b0, 7'h28, 32'h0000_0000, 8'd4}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        check(req, 64'(v), 64'(exp));
    endtask

    task automatic pulse(input int src);
        @(negedge clk);
        src_evt = '0;
        src_evt[src] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 user_irq", 64'(user_irq), 64'd0);
        check("R1 sys_irq", 64'(sys_irq), 64'd0);
        rd_chk("R1 routing", 7'h08, 32'h0);
        rd_chk("R1 user enable", 7'h44, 32'h0);
        rd_chk("R1 user status", 7'h58, 32'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][47]) begin
                bus_wr(VEC[i][46:40], VEC[i][39:8]);
            end else begin
                rd_chk($sformatf("R%0d vector %0d", VEC[i][7:0], i),
                       VEC[i][46:40], VEC[i][39:8]);
            end
        end

        // R6 user-routed event is sticky
        pulse(5);
        rd_chk("R6 user status after event", 7'h58, 32'h20);
        check("R8 output off while disabled", 64'(user_irq), 64'd0);
        bus_wr(7'h40, 32'h20);
        check("R8 output follows enable", 64'(user_irq), 64'h20);

        // R6 system-routed event
        bus_wr(7'h08, 32'hFFFF_FFBF);
        pulse(6);
        rd_chk("R6 system status", 7'h28, 32'h40);
        rd_chk("R6 user status unchanged", 7'h58, 32'h20);
        check("R9 sys_irq off while disabled", 64'(sys_irq), 64'd0);
        bus_wr(7'h10, 32'h40);
        check("R9 sys_irq on", 64'(sys_irq), 64'd1);
        check("R8 system event leaves user_irq", 64'(user_irq), 64'h20);

        // R7 event and clear on the same edge
        @(negedge clk);
        src_evt[5] = 1'b1; wr_en = 1'b1; addr = 7'h50; wdata = 32'h20;
        @(posedge clk);
        @(negedge clk);
        src_evt = '0; wr_en = 1'b0;
        rd_chk("R7 set beats clear", 7'h58, 32'h20);
        bus_wr(7'h50, 32'h20);
        rd_chk("R4 clear after collision", 7'h58, 32'h0);
        check("R8 output drops with status", 64'(user_irq), 64'd0);

        // R3 reserved source and bank 1 routing
        pulse(35);
        rd_chk("R3 reserved sys", 7'h2C, 32'h0);
        rd_chk("R3 reserved user", 7'h5C, 32'h0);
        pulse(40);
        rd_chk("R6 bank1 source 40", 7'h5C, 32'h100);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 user_irq after reset", 64'(user_irq), 64'd0);
        check("R1 sys_irq after reset", 64'(sys_irq), 64'd0);
        rd_chk("R1 routing after reset", 7'h08, 32'h0);
        rd_chk("R1 sys enable after reset", 7'h10, 32'h0);
        rd_chk("R1 bank1 status after reset", 7'h5C, 32'h0);

        summary();
        $finish;
    end

endmodule